// File: doc/BRIEF.md
# Serial Port Register Unit with Interrupt Identification

This block is a byte-wide asynchronous serial port seen by a host through a small word-aligned register window. The host loads bytes to send, reads received bytes, sets the line format and the bit rate, and learns why the single interrupt line is asserted by reading a prioritised source code. The block has one transmit holding slot in front of a shift register and one receive buffer behind a shift register, so at most one byte waits in each direction.

The bit rate comes from a 16-bit divisor that produces a tick at sixteen times the bit rate (divisor = clock / (16 x baud)). Each bit lasts sixteen ticks. Frames carry one low start bit, eight data bits sent least significant first, an optional parity bit and one high stop bit. The receiver confirms the start bit at its midpoint and samples every later bit at its midpoint. The divisor bytes sit behind a latch-select bit, at the same offsets as the data and interrupt-enable registers.

Top module: `serial_port_unit`

## Requirements
- R1: After reset the registers read: line status (0x14) 0x60, interrupt identification (0x08) 0x01, interrupt enable (0x04) 0x00, line control (0x0C) 0x03, transmitter enable (0x30) 0x80, divisor 0x0001. The irq output is low and txd is high.
- R2: While line control bit 7 is set, offset 0x00 reads and writes the divisor low byte and offset 0x04 the divisor high byte. The interrupt enable register keeps its value across those writes.
- R3: A byte written to offset 0x00 with bit 7 clear goes out on txd as a low start bit, eight data bits least significant first and a high stop bit. txd is high between frames.
- R4: Line control bit 3 adds a parity bit after the data. Bit 4 set makes the count of ones in data plus parity even, and bit 4 clear makes it odd. The receiver accepts and skips the parity bit.
- R5: Line status bit 5 is 1 when the holding slot is empty. Bit 6 is 1 only when the holding slot and the shift register are both empty.
- R6: While transmitter enable bit 7 is 0, a byte in the holding slot is not started: txd stays high and line status bit 5 stays 0. Setting bit 7 releases the byte.
- R7: A received byte sets line status bit 0 and is read at offset 0x00. That read clears bit 0.
- R8: A byte that arrives while bit 0 is still set replaces the held byte and sets line status bit 1. A line status read clears bit 1.
- R9: With enable bit 0 set, a byte waiting in the receive buffer drives irq high, and the identification register reads 0x04 (code 2 in bits [3:1], bit 0 low).
- R10: With enable bit 1 set, a byte moving from the holding slot into the shift register raises a transmit-empty condition. irq goes high and identification reads 0x02. Reading identification while it shows that code clears the condition, and so does writing a new byte.
- R11: When both sources are pending and enabled, identification reports the receive source (0x04) first. The transmit source (0x02) is reported once the receive buffer is read.
- R12: The bit period is 16 x divisor clock cycles. Changing the divisor changes the txd bit timing to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of a read access |
| irq | output | 1 | Interrupt request, high while an enabled source is pending |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |

## Verification
A wrong flag inside the block shows up on the next register read. A stuck receive-ready or transmit-pending bit shows as irq staying high and as a wrong identification code. A lost holding-slot flag shows as line status bit 5 or 6 reading wrong within a cycle of the write. Errors in the shift state or the baud counter show within one frame as a data, parity or stop bit out of place on txd. The scoreboard decodes txd at the expected bit period and compares each frame against the byte queued when it was written.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_IER  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_IIR  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_LCR  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_LSR  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_TER  = 6'h30;

  localparam logic [2:0] CODE_NONE = 3'd0;
  localparam logic [2:0] CODE_THRE = 3'd1;
  localparam logic [2:0] CODE_RDA  = 3'd2;

  // control -> datapath strobes
  typedef struct packed {
    logic wrThr;
    logic wrDivLo;
    logic wrDivHi;
    logic rdRbr;
    logic rdLsr;
    logic clrThrPend;
  } dpStrobes_t;

  // datapath -> control status
  typedef struct packed {
    logic        rxReady;
    logic        overrun;
    logic        thrEmpty;
    logic        txIdle;
    logic        thrPend;
    logic [7:0]  rxByte;
    logic [15:0] divisor;
  } dpStatus_t;

  typedef enum logic [2:0] {
    SH_IDLE, SH_START, SH_DATA, SH_PARITY, SH_STOP
  } shState_t;
endpackage

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
  import serial_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              irq,
  input  dpStatus_t         st,
  output dpStrobes_t        stb,
  output logic              parityEn,
  output logic              parityEven,
  output logic              txEnable
);
  logic [7:0] lcrQ;
  logic [1:0] ierQ;
  logic       terQ;
  logic       dlab, isWr, isRd, rxInt, thrInt;
  logic [2:0] intCode;

  assign dlab   = lcrQ[7];
  assign isWr   = busSel &  busWr;
  assign isRd   = busSel & ~busWr;
  assign rxInt  = ierQ[0] & st.rxReady;
  assign thrInt = ierQ[1] & st.thrPend;
  assign irq    = rxInt | thrInt;

  // receive source outranks transmit source
  always_comb begin
    if (rxInt)       intCode = CODE_RDA;
    else if (thrInt) intCode = CODE_THRE;
    else             intCode = CODE_NONE;
  end

  always_comb begin
    stb            = '0;
    stb.wrThr      = isWr && busAddr == OFS_DATA && !dlab;
    stb.wrDivLo    = isWr && busAddr == OFS_DATA &&  dlab;
    stb.wrDivHi    = isWr && busAddr == OFS_IER  &&  dlab;
    stb.rdRbr      = isRd && busAddr == OFS_DATA && !dlab;
    stb.rdLsr      = isRd && busAddr == OFS_LSR;
    stb.clrThrPend = isRd && busAddr == OFS_IIR && intCode == CODE_THRE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lcrQ <= 8'h03;
      ierQ <= 2'b00;
      terQ <= 1'b1;
    end else if (isWr) begin
      if (busAddr == OFS_LCR) lcrQ <= busWdata;
      if (busAddr == OFS_IER && !dlab) ierQ <= busWdata[1:0];
      if (busAddr == OFS_TER) terQ <= busWdata[7];
    end
  end

  always_comb begin
    busRdata = 8'h00;
    if (isRd) begin
      unique case (busAddr)
        OFS_DATA: busRdata = dlab ? st.divisor[7:0]  : st.rxByte;
        OFS_IER:  busRdata = dlab ? st.divisor[15:8] : {6'b0, ierQ};
        OFS_IIR:  busRdata = {4'b0000, intCode, ~irq};
        OFS_LCR:  busRdata = lcrQ;
        OFS_LSR:  busRdata = {1'b0, st.txIdle, st.thrEmpty, 3'b000,
                              st.overrun, st.rxReady};
        OFS_TER:  busRdata = {terQ, 7'b0};
        default:  busRdata = 8'h00;
      endcase
    end
  end

  assign parityEn   = lcrQ[3];
  assign parityEven = lcrQ[4];
  assign txEnable   = terQ;

  // R2: a divisor-high write leaves the enable register alone
  p_div_alias_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && busAddr == OFS_IER && dlab) |=> $stable(ierQ));

  // R10: acknowledging the transmit-empty source drops it in the datapath
  p_iir_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrThrPend |=> !st.thrPend);
endmodule

// File: rtl/serial_port_dp.sv
module serial_port_dp
  import serial_port_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DIV_RESET = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobes_t stb,
  input  logic [7:0] wdata,
  input  logic       parityEn,
  input  logic       parityEven,
  input  logic       txEnable,
  input  logic       rxd,
  output logic       txd,
  output dpStatus_t  st
);
  localparam int unsigned PH_W   = 4;
  localparam logic [PH_W-1:0] PH_LAST = 4'd15;
  localparam logic [PH_W-1:0] PH_MID  = 4'd7;

  // ---------------- baud tick (16x) ----------------
  logic [DIV_W-1:0] divQ, baudCnt;
  logic             tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ <= DIV_W'(DIV_RESET);
    end else begin
      if (stb.wrDivLo) divQ[7:0]       <= wdata;
      if (stb.wrDivHi) divQ[DIV_W-1:8] <= wdata[DIV_W-9:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || divQ == '0) begin
      baudCnt <= '0;
      tick    <= 1'b0;
    end else if (baudCnt == '0) begin
      baudCnt <= divQ - DIV_W'(1);
      tick    <= 1'b1;
    end else begin
      baudCnt <= baudCnt - DIV_W'(1);
      tick    <= 1'b0;
    end
  end

  // ---------------- transmitter ----------------
  logic [7:0]      thrQ, txShift;
  logic            thrFull, thrPendQ, txdQ, txParity;
  shState_t        txState;
  logic [PH_W-1:0] txPh;
  logic [2:0]      txBit;
  logic            txLoad, txBitEnd;

  assign txLoad   = thrFull && txEnable && txState == SH_IDLE;
  assign txBitEnd = tick && txPh == PH_LAST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrQ     <= '0;
      thrFull  <= 1'b0;
      thrPendQ <= 1'b0;
    end else begin
      if (stb.wrThr) begin
        thrQ    <= wdata;
        thrFull <= 1'b1;
      end else if (txLoad) begin
        thrFull <= 1'b0;
      end
      if (stb.wrThr || stb.clrThrPend) thrPendQ <= 1'b0;
      else if (txLoad)                 thrPendQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState  <= SH_IDLE;
      txdQ     <= 1'b1;
      txPh     <= '0;
      txBit    <= '0;
      txShift  <= '0;
      txParity <= 1'b0;
    end else begin
      if (tick && txState != SH_IDLE) txPh <= txPh + 4'd1;
      unique case (txState)
        SH_IDLE: begin
          txdQ <= 1'b1;
          if (txLoad) begin
            txShift  <= thrQ;
            txParity <= parityEven ? ^thrQ : ~^thrQ;
            txdQ     <= 1'b0;
            txPh     <= '0;
            txState  <= SH_START;
          end
        end
        SH_START: if (txBitEnd) begin
          txBit   <= '0;
          txdQ    <= txShift[0];
          txState <= SH_DATA;
        end
        SH_DATA: if (txBitEnd) begin
          if (txBit == 3'd7) begin
            txdQ    <= parityEn ? txParity : 1'b1;
            txState <= parityEn ? SH_PARITY : SH_STOP;
          end else begin
            txBit   <= txBit + 3'd1;
            txShift <= txShift >> 1;
            txdQ    <= txShift[1];
          end
        end
        SH_PARITY: if (txBitEnd) begin
          txdQ    <= 1'b1;
          txState <= SH_STOP;
        end
        SH_STOP: if (txBitEnd) txState <= SH_IDLE;
        default: txState <= SH_IDLE;
      endcase
    end
  end

  assign txd = txdQ;

  // ---------------- receiver ----------------
  logic [1:0]      rxSync;
  logic            rxS;
  shState_t        rxState;
  logic [PH_W-1:0] rxPh;
  logic [2:0]      rxBit;
  logic [7:0]      rxShift, rxBufQ;
  logic            rxReadyQ, ovrQ, rxDone, rxBitEnd;

  assign rxS      = rxSync[1];
  assign rxBitEnd = tick && rxPh == PH_LAST;
  assign rxDone   = rxState == SH_STOP && rxBitEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync  <= 2'b11;
      rxState <= SH_IDLE;
      rxPh    <= '0;
      rxBit   <= '0;
      rxShift <= '0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (tick && rxState != SH_IDLE) rxPh <= rxPh + 4'd1;
      unique case (rxState)
        SH_IDLE: if (!rxS) begin
          rxPh    <= '0;
          rxState <= SH_START;
        end
        SH_START: if (tick && rxPh == PH_MID) begin
          rxPh    <= '0;
          rxBit   <= '0;
          rxState <= rxS ? SH_IDLE : SH_DATA;
        end
        SH_DATA: if (rxBitEnd) begin
          rxShift <= {rxS, rxShift[7:1]};
          rxBit   <= rxBit + 3'd1;
          if (rxBit == 3'd7) rxState <= parityEn ? SH_PARITY : SH_STOP;
        end
        SH_PARITY: if (rxBitEnd) rxState <= SH_STOP;
        SH_STOP:   if (rxBitEnd) rxState <= SH_IDLE;
        default:   rxState <= SH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBufQ   <= '0;
      rxReadyQ <= 1'b0;
      ovrQ     <= 1'b0;
    end else begin
      if (rxDone) begin
        rxBufQ   <= rxShift;
        rxReadyQ <= 1'b1;
      end else if (stb.rdRbr) begin
        rxReadyQ <= 1'b0;
      end
      if (rxDone && rxReadyQ && !stb.rdRbr) ovrQ <= 1'b1;
      else if (stb.rdLsr)                   ovrQ <= 1'b0;
    end
  end

  always_comb begin
    st          = '0;
    st.rxReady  = rxReadyQ;
    st.overrun  = ovrQ;
    st.thrEmpty = !thrFull;
    st.txIdle   = !thrFull && txState == SH_IDLE;
    st.thrPend  = thrPendQ;
    st.rxByte   = rxBufQ;
    st.divisor  = divQ;
  end

  // R3: the line rests high whenever no frame is being shifted
  p_txd_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txState == SH_IDLE) |-> txd);

  // R6: a disabled transmitter never leaves idle
  p_ter_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && txState == SH_IDLE) |=> (txState == SH_IDLE));

  // R7: reading the buffer drops the ready flag unless a byte lands
  p_rbr_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdRbr && !rxDone) |=> !rxReadyQ);

  // R8: overrun only appears on top of an unread byte
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrQ) |-> (rxReadyQ && $past(rxReadyQ)));
endmodule

// File: rtl/serial_port_unit.sv
module serial_port_unit
  import serial_port_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DIV_RESET = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              irq,
  input  logic              rxd,
  output logic              txd
);
  dpStrobes_t stb;
  dpStatus_t  st;
  logic       parityEn, parityEven, txEnable;

  serial_port_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .irq        (irq),
    .st         (st),
    .stb        (stb),
    .parityEn   (parityEn),
    .parityEven (parityEven),
    .txEnable   (txEnable)
  );

  serial_port_dp #(
    .DIV_W     (DIV_W),
    .DIV_RESET (DIV_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wdata      (busWdata),
    .parityEn   (parityEn),
    .parityEven (parityEven),
    .txEnable   (txEnable),
    .rxd        (rxd),
    .txd        (txd),
    .st         (st)
  );
endmodule

// File: tb/serial_port_unit_tb.sv
module serial_port_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq, txd;
  logic       rxd = 1'b1;

  int nChecks = 0, nFail = 0, cycles = 0;
  int bitCyc = 16;
  bit parOn = 0, parEven = 0, doneFlag = 0;
  string monTag = "R3";
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  serial_port_unit u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .rxd(rxd), .txd(txd)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic expectReg(input string req, input string what,
                           input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    busRead(a, v);
    check(req, what, v, exp);
  endtask

  // driver side of the scoreboard
  task automatic sendByte(input logic [7:0] b);
    expQ.push_back(b);
    busWrite(6'h00, b);
  endtask

  task automatic drain();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      busRead(6'h14, v);
      if (v[6]) break;
    end
    repeat (4) @(negedge clk);
    check("R3", "scoreboard empty", 8'(expQ.size()), 8'd0);
  endtask

  task automatic driveRx(input logic [7:0] b, input bit withPar, input bit even);
    @(negedge clk); rxd = 0;
    repeat (bitCyc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bitCyc) @(negedge clk);
    end
    if (withPar) begin
      rxd = even ? ^b : ~^b;
      repeat (bitCyc) @(negedge clk);
    end
    rxd = 1;
    repeat (bitCyc) @(negedge clk);
  endtask

  task automatic setDivisor(input logic [15:0] d);
    busWrite(6'h0C, 8'h83);
    busWrite(6'h00, d[7:0]);
    busWrite(6'h04, d[15:8]);
    busWrite(6'h0C, 8'h03);
    bitCyc = 16 * int'(d);
  endtask

  // monitor side of the scoreboard: decode txd at the expected bit period
  initial begin : txMonitor
    logic [7:0] got, exp;
    logic gotPar, gotStop;
    forever begin
      @(negedge clk);
      if (rstN && txd === 1'b0) begin
        repeat (bitCyc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bitCyc) @(negedge clk);
          got[i] = txd;
        end
        gotPar = 1'b0;
        if (parOn) begin
          repeat (bitCyc) @(negedge clk);
          gotPar = txd;
        end
        repeat (bitCyc) @(negedge clk);
        gotStop = txd;
        if (expQ.size() == 0) begin
          check(monTag, "unexpected frame on txd", got, 8'hxx);
        end else begin
          exp = expQ.pop_front();
          check(monTag, "txd data byte", got, exp);
          check("R3", "stop bit", {7'b0, gotStop}, 8'h01);
          if (parOn)
            check("R4", "parity bit", {7'b0, gotPar},
                  {7'b0, parEven ? ^exp : ~^exp});
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 150000) begin
        nChecks++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finishRun();
      end
    end
  end

  initial begin : mainFlow
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1", "irq after reset", {7'b0, irq}, 8'h00);
    check("R1", "txd after reset", {7'b0, txd}, 8'h01);
    expectReg("R1", "line status", 6'h14, 8'h60);
    expectReg("R1", "identification", 6'h08, 8'h01);
    expectReg("R1", "interrupt enable", 6'h04, 8'h00);
    expectReg("R1", "line control", 6'h0C, 8'h03);
    expectReg("R1", "transmitter enable", 6'h30, 8'h80);
    busWrite(6'h0C, 8'h83);
    expectReg("R1", "divisor low at reset", 6'h00, 8'h01);

    // R2 divisor aliasing
    busWrite(6'h00, 8'h02);
    busWrite(6'h04, 8'h00);
    expectReg("R2", "divisor low", 6'h00, 8'h02);
    expectReg("R2", "divisor high", 6'h04, 8'h00);
    busWrite(6'h0C, 8'h03);
    expectReg("R2", "enable untouched", 6'h04, 8'h00);
    bitCyc = 32;

    // R12 frame at doubled bit period
    monTag = "R12";
    sendByte(8'hA5);
    drain();
    setDivisor(16'd1);
    monTag = "R3";

    // R5 holding slot / shifter flags, R3 frames
    sendByte(8'h3C);
    expectReg("R5", "slot empty, shifter busy", 6'h14, 8'h20);
    sendByte(8'hC3);
    expectReg("R5", "slot full", 6'h14, 8'h00);
    drain();
    expectReg("R5", "all idle", 6'h14, 8'h60);

    // R4 parity even then odd, plus receive with parity
    busWrite(6'h0C, 8'h1B); parOn = 1; parEven = 1;
    sendByte(8'h07);
    drain();
    busWrite(6'h0C, 8'h0B); parEven = 0;
    sendByte(8'h55);
    drain();
    busWrite(6'h0C, 8'h1B); parEven = 1;
    driveRx(8'h9E, 1, 1);
    expectReg("R4", "rx byte with parity", 6'h00, 8'h9E);
    busWrite(6'h0C, 8'h03); parOn = 0;

    // R6 transmitter disable
    busWrite(6'h30, 8'h00);
    sendByte(8'h81);
    repeat (400) @(negedge clk);
    check("R6", "byte held while disabled", 8'(expQ.size()), 8'd1);
    check("R6", "txd high while disabled", {7'b0, txd}, 8'h01);
    expectReg("R6", "slot still full", 6'h14, 8'h00);
    busWrite(6'h30, 8'h80);
    drain();

    // R7 receive
    driveRx(8'h4D, 0, 0);
    expectReg("R7", "ready set", 6'h14, 8'h61);
    expectReg("R7", "rx byte", 6'h00, 8'h4D);
    expectReg("R7", "ready cleared", 6'h14, 8'h60);

    // R8 overrun
    driveRx(8'h11, 0, 0);
    driveRx(8'h22, 0, 0);
    expectReg("R8", "overrun and ready", 6'h14, 8'h63);
    expectReg("R8", "newest byte kept", 6'h00, 8'h22);
    expectReg("R8", "overrun cleared", 6'h14, 8'h60);

    // R9 receive interrupt
    busWrite(6'h04, 8'h01);
    check("R9", "irq idle", {7'b0, irq}, 8'h00);
    driveRx(8'h5A, 0, 0);
    check("R9", "irq on rx", {7'b0, irq}, 8'h01);
    expectReg("R9", "ident rx", 6'h08, 8'h04);
    expectReg("R9", "rx byte", 6'h00, 8'h5A);
    check("R9", "irq after read", {7'b0, irq}, 8'h00);
    expectReg("R9", "ident none", 6'h08, 8'h01);

    // R10 transmit-empty interrupt
    busWrite(6'h04, 8'h02);
    sendByte(8'h66);
    repeat (3) @(negedge clk);
    check("R10", "irq on load", {7'b0, irq}, 8'h01);
    expectReg("R10", "ident thre", 6'h08, 8'h02);
    check("R10", "irq after ident read", {7'b0, irq}, 8'h00);
    expectReg("R10", "ident none", 6'h08, 8'h01);
    drain();
    sendByte(8'h01);
    repeat (3) @(negedge clk);
    check("R10", "irq before refill", {7'b0, irq}, 8'h01);
    sendByte(8'h02);
    check("R10", "irq cleared by write", {7'b0, irq}, 8'h00);
    drain();
    check("R10", "irq after second load", {7'b0, irq}, 8'h01);
    expectReg("R10", "ident thre again", 6'h08, 8'h02);

    // R11 priority
    busWrite(6'h04, 8'h03);
    sendByte(8'h44);
    driveRx(8'h99, 0, 0);
    expectReg("R11", "rx first", 6'h08, 8'h04);
    expectReg("R11", "rx byte", 6'h00, 8'h99);
    expectReg("R11", "then thre", 6'h08, 8'h02);
    expectReg("R11", "then none", 6'h08, 8'h01);
    drain();
    busWrite(6'h04, 8'h00);

    finishRun();
  end
endmodule